// File: doc/BRIEF.md
# Bit-Serial Stack Logic Core

This block is the execution unit of a small scan-based logic controller. It consumes one 8-bit opcode per accepted byte from an instruction stream and works on a data stack whose entries are single bits. Programs read eight input bits and eight output registers, plus a handful of special-function bits shared with a timer and a servo pulse generator that live outside the block. They combine those bits with truth-table logic and drive the output registers back. The same program runs again every scan. A scan-start strobe freezes the input pins for the whole scan and keeps the previous scan's values, so that rising and falling edges are judged between scan starts and not between clocks.

Instruction bytes arrive on a valid/ready pair. Ready drops only while the scan-start strobe is high, so a byte is never executed in the same cycle as a scan boundary. The core is a two-state machine. In state OPCODE each accepted byte is decoded and executed. A parameter opcode takes transition OPCODE->OPERAND, and the next accepted byte is then written to the selected parameter (transition OPERAND->OPCODE). A scan-start strobe in OPERAND also returns the machine to OPCODE and abandons the pending write.

Top module: `bitlogic_core`

## Requirements
- R1: After an active-low reset all output registers, the enable and position bits, both parameters and every stack entry read 0, the stack pointer is at its start position, the machine is in OPCODE, and ready is 1.
- R2: `instr_ready_o` equals the inverse of `scan_start_i`. A byte is acted on only when valid and ready are both high. Its effect on the registered outputs is visible after the next rising clock edge.
- R3: A cycle with `scan_start_i` high loads the input pins into the current input snapshot and moves the old current snapshot into the previous snapshot. It does the same for the output registers. Reads of an input between strobes return the snapshot, not the pins.
- R4: Register opcodes have bit 7 = 0, with bit 6 = 0 for I/O. Bits 5:4 select push (00), pop (01), set (10) or reset (11). Push 0000_IRRR pushes input RRR when I=1 and output RRR when I=0. Pop 0001_xRRR moves the top of stack into output RRR and removes it.
- R5: Set (0010_xRRR) forces the target to 1 only when the top of stack is 1. Reset (0011_xRRR) forces it to 0 only when the top of stack is 1. Neither changes the stack.
- R6: Special-function opcodes are 01pp_SSSS, with the same push/pop/set/reset codes as R4. Index 0 is timer enable, 2 is servo enable and 3 is servo position; these are writable. Index 1 reads `tmr_state_i` and index 4 reads `srv_state_i`; writes to them are ignored. Other indices read 0.
- R7: Any opcode 10xx_TTTT not named in R8 pops two bits and pushes TTTT bit (3 - {next, top}). Examples: 0xA1 AND, 0xA7 OR, 0xA6 XOR, 0xAE NAND, 0xA8 NOR, 0xAD next-implies-top.
- R8: Fixed stack opcodes: 0x8C pushes a copy of the top, 0x8A pushes a copy of the next, 0xAA drops the top, 0xB0 pushes 0, 0xBF pushes 1, 0x93 inverts the top in place, and 0xA5 pushes the inverse of the next.
- R9: 0xF2 exchanges top and next. 0xF3 brings the third entry to the top, with the old top becoming the next and the old next becoming the third. 0xF0 fills every entry with 0 and 0xF1 fills every entry with 1. Other 1111_xxxx codes change nothing.
- R10: 1100_IRRR pushes 1 when the selected bit (input for I=1, output for I=0) is 1 in the current snapshot and 0 in the previous one, else 0. 1101_IRRR pushes 1 for the opposite change.
- R11: Opcode 1110_xPPP makes the next accepted byte a parameter value instead of an opcode. For PPP=1 its low 4 bits become `tmr_div_o`, and for PPP=7 its low 5 bits become `srv_set_o`; other PPP values store nothing. A scan-start strobe while the value is pending cancels it.
- R12: The stack holds 16 one-bit entries in a ring. Pushing past 16 overwrites the oldest entry. Sixteen pops return to the same entry. Neither condition is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid_i | input | 1 | Instruction byte valid |
| instr_byte_i | input | 8 | Instruction or parameter byte |
| instr_ready_o | output | 1 | Core can accept a byte |
| scan_start_i | input | 1 | Scan boundary strobe |
| in_pins_i | input | 8 | Raw input bits |
| out_o | output | 8 | Output registers |
| tmr_en_o | output | 1 | Timer enable bit |
| tmr_state_i | input | 1 | Timer output level, read-only bit |
| srv_en_o | output | 1 | Servo enable bit |
| srv_pos_o | output | 1 | Servo position select bit |
| srv_state_i | input | 1 | Servo output level, read-only bit |
| tmr_div_o | output | 4 | Timer divider parameter |
| srv_set_o | output | 5 | Servo set-position parameter |

## Verification
Every accepted opcode updates the output registers, the special-function bits and the parameters at the first rising edge after acceptance, so their result is due one cycle later. The bench drives each byte on a falling edge and reads the result on the following falling edge. A scan strobe is likewise taken at one edge, and the snapshots it loads are observed through later edge and push opcodes. Stack contents have no port of their own, so they are checked one cycle after a pop moves the top entry into an output register.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

    typedef enum logic {
        ST_OPCODE,
        ST_OPERAND
    } core_state_e;

    typedef enum logic [2:0] {
        SK_HOLD,
        SK_PUSH,
        SK_POP,
        SK_REPL,
        SK_MERGE,
        SK_SWAP,
        SK_ROT,
        SK_FILL
    } stk_op_e;

    typedef enum logic [3:0] {
        DS_ZERO,
        DS_ONE,
        DS_TOS,
        DS_NTOS,
        DS_NOS,
        DS_NNOS,
        DS_TRUTH,
        DS_REG,
        DS_RISE,
        DS_FALL
    } din_sel_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_LOAD,
        WR_SET,
        WR_CLEAR
    } wr_act_e;

    typedef struct packed {
        stk_op_e  sop;
        din_sel_e dsel;
        wr_act_e  act;
        logic     to_sfr;
        logic     is_param;
    } dec_t;

endpackage

// File: rtl/bitlogic_decode.sv
module bitlogic_decode
    import bitlogic_pkg::*;
(
    input  logic [7:0] op_i,
    output dec_t       dec_o
);

    always_comb begin
        dec_o = '{sop: SK_HOLD, dsel: DS_ZERO, act: WR_NONE, to_sfr: 1'b0, is_param: 1'b0};
        unique case (op_i[7:6])
            2'b00, 2'b01: begin
                dec_o.to_sfr = op_i[6];
                unique case (op_i[5:4])
                    2'b00: begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_REG; end
                    2'b01: begin dec_o.sop = SK_POP;  dec_o.act = WR_LOAD; end
                    2'b10: dec_o.act = WR_SET;
                    2'b11: dec_o.act = WR_CLEAR;
                endcase
            end
            2'b10: begin
                case (op_i)
                    8'h8C:   begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_TOS;  end
                    8'h8A:   begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_NOS;  end
                    8'hAA:   dec_o.sop = SK_POP;
                    8'hB0:   begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_ZERO; end
                    8'hBF:   begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_ONE;  end
                    8'h93:   begin dec_o.sop = SK_REPL; dec_o.dsel = DS_NTOS; end
                    8'hA5:   begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_NNOS; end
                    default: begin dec_o.sop = SK_MERGE; dec_o.dsel = DS_TRUTH; end
                endcase
            end
            2'b11: begin
                unique case (op_i[5:4])
                    2'b00: begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_RISE; end
                    2'b01: begin dec_o.sop = SK_PUSH; dec_o.dsel = DS_FALL; end
                    2'b10: dec_o.is_param = 1'b1;
                    2'b11: begin
                        case (op_i[3:0])
                            4'h0:    begin dec_o.sop = SK_FILL; dec_o.dsel = DS_ZERO; end
                            4'h1:    begin dec_o.sop = SK_FILL; dec_o.dsel = DS_ONE;  end
                            4'h2:    dec_o.sop = SK_SWAP;
                            4'h3:    dec_o.sop = SK_ROT;
                            default: dec_o.sop = SK_HOLD;
                        endcase
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/bitlogic_stack.sv
module bitlogic_stack
    import bitlogic_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  stk_op_e op_i,
    input  logic    din_i,
    output logic    tos_o,
    output logic    nos_o,
    output logic    third_o
);

    // DEPTH must be a power of two so the pointer wraps as a ring.
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    sp_q;
    logic [AW-1:0]    sp_up, sp_dn, sp_dn2;

    assign sp_up   = sp_q + 1'b1;
    assign sp_dn   = sp_q - 1'b1;
    assign sp_dn2  = sp_q - 2'd2;
    assign tos_o   = mem_q[sp_q];
    assign nos_o   = mem_q[sp_dn];
    assign third_o = mem_q[sp_dn2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            sp_q  <= '0;
        end else begin
            case (op_i)
                SK_PUSH: begin
                    sp_q         <= sp_up;
                    mem_q[sp_up] <= din_i;
                end
                SK_POP:  sp_q <= sp_dn;
                SK_REPL: mem_q[sp_q] <= din_i;
                SK_MERGE: begin
                    sp_q         <= sp_dn;
                    mem_q[sp_dn] <= din_i;
                end
                SK_SWAP: begin
                    mem_q[sp_q]  <= mem_q[sp_dn];
                    mem_q[sp_dn] <= mem_q[sp_q];
                end
                SK_ROT: begin
                    mem_q[sp_q]   <= mem_q[sp_dn2];
                    mem_q[sp_dn]  <= mem_q[sp_q];
                    mem_q[sp_dn2] <= mem_q[sp_dn];
                end
                SK_FILL: mem_q <= {DEPTH{din_i}};
                default: ;
            endcase
        end
    end

    // R12
    push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SK_PUSH) |=> (sp_q == AW'($past(sp_q) + 1'b1)) && (tos_o == $past(din_i)));

    // R9
    fill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SK_FILL) |=> (mem_q == {DEPTH{$past(din_i)}}));

endmodule

// File: rtl/bitlogic_snap.sv
module bitlogic_snap #(
    parameter int NIO = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_i,
    input  logic [NIO-1:0] pins_i,
    input  logic [NIO-1:0] outs_i,
    output logic [NIO-1:0] in_cur_o,
    output logic [NIO-1:0] in_prev_o,
    output logic [NIO-1:0] out_cur_o,
    output logic [NIO-1:0] out_prev_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cur_o   <= '0;
            in_prev_o  <= '0;
            out_cur_o  <= '0;
            out_prev_o <= '0;
        end else if (scan_i) begin
            in_cur_o   <= pins_i;
            in_prev_o  <= in_cur_o;
            out_cur_o  <= outs_i;
            out_prev_o <= out_cur_o;
        end
    end

    // R3
    snap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_i |=> (in_cur_o == $past(pins_i)) && (in_prev_o == $past(in_cur_o)));

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_i |=> $stable(in_cur_o) && $stable(in_prev_o));

endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
    import bitlogic_pkg::*;
#(
    parameter int NIO   = 8,
    parameter int DEPTH = 16,
    parameter int DIV_W = 4,
    parameter int SET_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid_i,
    input  logic [7:0]       instr_byte_i,
    output logic             instr_ready_o,
    input  logic             scan_start_i,
    input  logic [NIO-1:0]   in_pins_i,
    output logic [NIO-1:0]   out_o,
    output logic             tmr_en_o,
    input  logic             tmr_state_i,
    output logic             srv_en_o,
    output logic             srv_pos_o,
    input  logic             srv_state_i,
    output logic [DIV_W-1:0] tmr_div_o,
    output logic [SET_W-1:0] srv_set_o
);

    localparam int IDX_W    = $clog2(NIO);
    localparam int SFR_SPAN = 16;
    localparam int NSFR     = 5;

    core_state_e state_q, state_d;
    dec_t        dec;
    stk_op_e     sk_op;
    logic        accept, exec_op, tos, nos, third, din, reg_bit, edge_cur, edge_prev;
    logic [IDX_W-1:0]    idx;
    logic [1:0]          tt_idx;
    logic [2:0]          pidx_q;
    logic [SFR_SPAN-1:0] sfr_rd;
    logic [NIO-1:0]      out_q, in_cur, in_prev, out_cur, out_prev;
    logic                tmr_en_q, srv_en_q, srv_pos_q;
    logic [DIV_W-1:0]    div_q;
    logic [SET_W-1:0]    set_q;

    bitlogic_decode u_dec (.op_i(instr_byte_i), .dec_o(dec));

    bitlogic_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .op_i(sk_op), .din_i(din),
        .tos_o(tos), .nos_o(nos), .third_o(third)
    );

    bitlogic_snap #(.NIO(NIO)) u_snap (
        .clk(clk), .rst_n(rst_n), .scan_i(scan_start_i), .pins_i(in_pins_i),
        .outs_i(out_q), .in_cur_o(in_cur), .in_prev_o(in_prev),
        .out_cur_o(out_cur), .out_prev_o(out_prev)
    );

    assign instr_ready_o = !scan_start_i;
    assign accept        = instr_valid_i && instr_ready_o;
    assign exec_op       = accept && (state_q == ST_OPCODE);
    assign sk_op         = exec_op ? dec.sop : SK_HOLD;
    assign idx           = instr_byte_i[IDX_W-1:0];
    assign tt_idx        = 2'd3 - {nos, tos};
    assign sfr_rd        = {{(SFR_SPAN-NSFR){1'b0}}, srv_state_i, srv_pos_q, srv_en_q, tmr_state_i, tmr_en_q};
    assign reg_bit       = dec.to_sfr ? sfr_rd[instr_byte_i[3:0]]
                         : (instr_byte_i[3] ? in_cur[idx] : out_q[idx]);
    assign edge_cur      = instr_byte_i[3] ? in_cur[idx]  : out_cur[idx];
    assign edge_prev     = instr_byte_i[3] ? in_prev[idx] : out_prev[idx];

    always_comb begin
        unique case (dec.dsel)
            DS_ONE:   din = 1'b1;
            DS_TOS:   din = tos;
            DS_NTOS:  din = !tos;
            DS_NOS:   din = nos;
            DS_NNOS:  din = !nos;
            DS_TRUTH: din = instr_byte_i[tt_idx];
            DS_REG:   din = reg_bit;
            DS_RISE:  din = edge_cur && !edge_prev;
            DS_FALL:  din = !edge_cur && edge_prev;
            default:  din = 1'b0;
        endcase
    end

    function automatic logic next_bit(wr_act_e a, logic cur, logic t);
        case (a)
            WR_LOAD:  return t;
            WR_SET:   return cur | t;
            WR_CLEAR: return cur & !t;
            default:  return cur;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE:  if (exec_op && dec.is_param) state_d = ST_OPERAND;
            ST_OPERAND: if (scan_start_i || accept)  state_d = ST_OPCODE;
        endcase
    end

    // Output and register updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            tmr_en_q  <= 1'b0;
            srv_en_q  <= 1'b0;
            srv_pos_q <= 1'b0;
            div_q     <= '0;
            set_q     <= '0;
            pidx_q    <= '0;
        end else begin
            if (exec_op && dec.act != WR_NONE) begin
                if (!dec.to_sfr) begin
                    out_q[idx] <= next_bit(dec.act, out_q[idx], tos);
                end else begin
                    case (instr_byte_i[3:0])
                        4'd0:    tmr_en_q  <= next_bit(dec.act, tmr_en_q, tos);
                        4'd2:    srv_en_q  <= next_bit(dec.act, srv_en_q, tos);
                        4'd3:    srv_pos_q <= next_bit(dec.act, srv_pos_q, tos);
                        default: ;
                    endcase
                end
            end
            if (exec_op && dec.is_param) pidx_q <= instr_byte_i[2:0];
            if (state_q == ST_OPERAND && accept) begin
                case (pidx_q)
                    3'd1:    div_q <= instr_byte_i[DIV_W-1:0];
                    3'd7:    set_q <= instr_byte_i[SET_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign out_o     = out_q;
    assign tmr_en_o  = tmr_en_q;
    assign srv_en_o  = srv_en_q;
    assign srv_pos_o = srv_pos_q;
    assign tmr_div_o = div_q;
    assign srv_set_o = set_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_q) && $stable(div_q) && $stable(set_q) && $stable(tmr_en_q));

    // R5
    set_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_op && !dec.to_sfr && dec.act == WR_SET && !tos) |=> $stable(out_q));

    // R11
    operand_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPERAND && accept) |=> (state_q == ST_OPCODE));

    // R11
    operand_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPERAND) |=> $stable(out_q) && $stable(srv_pos_q));

    // R9
    unused_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_op && instr_byte_i[7:4] == 4'hF && instr_byte_i[3:2] != 2'b00) |=> $stable(out_q));

endmodule

// File: tb/bitlogic_core_test.sv
module bitlogic_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPROG      = 66;

    // {opcode, expected out_o after it}; inputs latched as 8'hA5 beforehand
    localparam logic [15:0] PROG [0:NPROG-1] = '{
        16'h0800, 16'h8C00, 16'h1801, 16'h9301, 16'h1901, 16'h0A01, 16'h0B01, 16'hA101,
        16'h1A01, 16'h0A01, 16'h0B01, 16'hA701, 16'h1B09, 16'h0A09, 16'h0B09, 16'hA609,
        16'h1C19, 16'h0D19, 16'h0819, 16'hAE19, 16'h1C09, 16'h0B09, 16'h0E09, 16'hA809,
        16'h1D29, 16'hB029, 16'h2E29, 16'hBF29, 16'h2E69, 16'h3868, 16'h1FE8, 16'h1F68,
        16'hBF68, 16'hB068, 16'hF268, 16'h1869, 16'h1969, 16'hBF69, 16'hB069, 16'h8A69,
        16'h196B, 16'h1969, 16'h196B, 16'hBF6B, 16'hB06B, 16'hA56B, 16'h186A, 16'h186A,
        16'h186B, 16'hBF6B, 16'hBF6B, 16'hB06B, 16'hF36B, 16'h1A6F, 16'h1A6B, 16'h1A6F,
        16'hBF6F, 16'hB06F, 16'hAD6F, 16'h1A6B, 16'hBF6B, 16'hB06B, 16'hAA6B, 16'h1A6F,
        16'h026F, 16'h1C7F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid_i = 1'b0;
    logic [7:0] instr_byte_i = 8'h00;
    logic       instr_ready_o;
    logic       scan_start_i = 1'b0;
    logic [7:0] in_pins_i = 8'h00;
    logic [7:0] out_o;
    logic       tmr_en_o, srv_en_o, srv_pos_o;
    logic       tmr_state_i = 1'b0;
    logic       srv_state_i = 1'b0;
    logic [3:0] tmr_div_o;
    logic [4:0] srv_set_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [7:0] snap;

    bitlogic_core uut (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_byte_i(instr_byte_i),
        .instr_ready_o(instr_ready_o), .scan_start_i(scan_start_i), .in_pins_i(in_pins_i),
        .out_o(out_o), .tmr_en_o(tmr_en_o), .tmr_state_i(tmr_state_i), .srv_en_o(srv_en_o),
        .srv_pos_o(srv_pos_o), .srv_state_i(srv_state_i), .tmr_div_o(tmr_div_o),
        .srv_set_o(srv_set_o)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_valid_i = 1'b0; scan_start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic exec(input logic [7:0] op);
        instr_valid_i = 1'b1; instr_byte_i = op;
        @(negedge clk);
        instr_valid_i = 1'b0;
    endtask

    task automatic scan(input logic [7:0] pins);
        in_pins_i = pins; scan_start_i = 1'b1;
        @(negedge clk);
        scan_start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 outputs", {8'h00, out_o}, 16'h0000);
        check("R1 sfr bits", {13'h0, tmr_en_o, srv_en_o, srv_pos_o}, 16'h0000);
        check("R1 params", {7'h0, tmr_div_o, srv_set_o}, 16'h0000);
        check("R1 ready", {15'h0, instr_ready_o}, 16'h0001);
        exec(8'h1F); // pop an empty stack: entries reset to 0
        check("R1 stack zero", {8'h00, out_o}, 16'h0000);

        // Table walk: R4 R5 R7 R8 R9
        scan(8'hA5);
        in_pins_i = 8'h00; // pins change, snapshot must hold (R3)
        for (int k = 0; k < NPROG; k++) begin
            exec(PROG[k][15:8]);
            check($sformatf("R4 R5 R7 R8 R9 step %0d op %0h", k, PROG[k][15:8]),
                  {8'h00, out_o}, {8'h00, PROG[k][7:0]});
        end

        // R2 handshake
        do_reset();
        exec(8'hBF);
        in_pins_i = 8'h00; scan_start_i = 1'b1; instr_valid_i = 1'b1; instr_byte_i = 8'h1D;
        #1 check("R2 ready low in scan", {15'h0, instr_ready_o}, 16'h0000);
        @(negedge clk);
        scan_start_i = 1'b0; instr_valid_i = 1'b0;
        check("R2 no exec in scan", {8'h00, out_o}, 16'h0000);
        #1 check("R2 ready back", {15'h0, instr_ready_o}, 16'h0001);
        instr_byte_i = 8'h1D;
        @(negedge clk);
        check("R2 valid low ignored", {8'h00, out_o}, 16'h0000);
        exec(8'h1D);
        check("R2 accepted", {8'h00, out_o}, 16'h0020);

        // R3 R10 edges between scan starts
        do_reset();
        scan(8'h00); scan(8'h01);
        exec(8'hC8); exec(8'h18);
        check("R10 rising i0", {15'h0, out_o[0]}, 16'h0001);
        exec(8'hD8); exec(8'h19);
        check("R10 falling i0 none", {15'h0, out_o[1]}, 16'h0000);
        scan(8'h00);
        exec(8'hD8); exec(8'h19);
        check("R10 falling i0", {15'h0, out_o[1]}, 16'h0001);
        exec(8'hC8); exec(8'h18);
        check("R10 rising i0 none", {15'h0, out_o[0]}, 16'h0000);
        scan(8'h00);
        in_pins_i = 8'h01;
        exec(8'h08); exec(8'h1A);
        check("R3 input frozen", {15'h0, out_o[2]}, 16'h0000);
        exec(8'hC8); exec(8'h1B);
        check("R10 no edge mid-scan", {15'h0, out_o[3]}, 16'h0000);
        scan(8'h00);
        exec(8'hBF); exec(8'h1F);
        exec(8'hC7); exec(8'h1C);
        check("R10 output edge waits scan", {15'h0, out_o[4]}, 16'h0000);
        scan(8'h00);
        exec(8'hC7); exec(8'h1C);
        check("R3 R10 output rising", {15'h0, out_o[4]}, 16'h0001);

        // R6 special-function bits
        do_reset();
        exec(8'hBF); exec(8'h50);
        check("R6 pop timer enable", {15'h0, tmr_en_o}, 16'h0001);
        exec(8'hBF); exec(8'h62);
        check("R6 set servo enable", {15'h0, srv_en_o}, 16'h0001);
        exec(8'h72);
        check("R6 reset servo enable", {15'h0, srv_en_o}, 16'h0000);
        exec(8'h53);
        check("R6 pop servo position", {15'h0, srv_pos_o}, 16'h0001);
        tmr_state_i = 1'b1; srv_state_i = 1'b1;
        exec(8'hBF); exec(8'h51); exec(8'h54);
        exec(8'h41); exec(8'h18);
        check("R6 read timer state", {15'h0, out_o[0]}, 16'h0001);
        exec(8'h44); exec(8'h19);
        check("R6 read servo state", {15'h0, out_o[1]}, 16'h0001);
        exec(8'hBF); exec(8'h49); exec(8'h1A);
        check("R6 unused index reads 0", {15'h0, out_o[2]}, 16'h0000);
        check("R6 other bits intact", {13'h0, tmr_en_o, srv_en_o, srv_pos_o}, 16'h0005);

        // R11 parameters
        do_reset();
        exec(8'hE1); exec(8'h0B);
        check("R11 divider", {12'h0, tmr_div_o}, 16'h000B);
        exec(8'hEF); exec(8'h18);
        check("R11 servo set", {11'h0, srv_set_o}, 16'h0018);
        check("R11 data not executed", {8'h00, out_o}, 16'h0000);
        exec(8'hE9); exec(8'h36);
        check("R11 x bit ignored", {12'h0, tmr_div_o}, 16'h0006);
        exec(8'hE3); exec(8'hFF);
        check("R11 other param", {7'h0, tmr_div_o, srv_set_o}, {7'h0, 4'h6, 5'h18});
        exec(8'hE1);
        scan(8'h00);
        exec(8'hBF); exec(8'h1E);
        check("R11 scan cancels", {7'h0, tmr_div_o, out_o[6], 4'h0}, {7'h0, 4'h6, 1'b1, 4'h0});

        // R9 fills and unused codes
        do_reset();
        exec(8'hF1);
        for (int k = 0; k < 5; k++) exec(8'hAA);
        exec(8'h1B);
        check("R9 set all", {15'h0, out_o[3]}, 16'h0001);
        exec(8'hF0); exec(8'h1B);
        check("R9 clear all", {15'h0, out_o[3]}, 16'h0000);
        exec(8'hBF); snap = out_o;
        exec(8'hFF); exec(8'hF7);
        check("R9 no-op outputs", {8'h00, out_o}, {8'h00, snap});
        exec(8'h1C);
        check("R9 no-op stack", {15'h0, out_o[4]}, 16'h0001);

        // R12 ring wrap
        do_reset();
        exec(8'hBF);
        for (int k = 0; k < 16; k++) exec(8'hAA);
        exec(8'h19);
        check("R12 underflow ring", {15'h0, out_o[1]}, 16'h0001);
        do_reset();
        exec(8'hB0);
        for (int k = 0; k < 16; k++) exec(8'hBF);
        for (int k = 0; k < 16; k++) exec(8'hAA);
        exec(8'h18);
        check("R12 overflow overwrite", {15'h0, out_o[0]}, 16'h0001);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule